// File: doc/BRIEF.md
# Serial programming host sequencer

This block is the host end of a four-byte serial programming link to a small microcontroller target. On a start strobe it takes over the target's reset pin and drives the serial clock and data-out lines itself. It holds the target in reset for a settling period and then sends the enable instruction. It checks that the target is in step by looking at the echo in the third byte, and it retries with a reset pulse if the echo is wrong. Once the link is up, it streams one program page word by word from a small local buffer, commits the page, and finishes with either a fixed write delay or busy polling.

The local buffer is read combinationally: the block presents a word index on `buf_addr` and expects the 16-bit word on `buf_word` in the same cycle. All delays are counted in system clocks and set by parameters. `HALF` sets each SCK phase, and it must cover at least three target clocks.

Top module: `spprog_host`

## Requirements
- R1: After reset, and whenever idle, `tgt_rst` is 1, `sck` is 0 and `mosi` is 0. `busy`, `done` and `err` are all 0 until the first start.
- R2: A start drives `tgt_rst` low while `sck` stays low. No SCK rising edge follows for at least `PWR_WAIT` clocks.
- R3: Each instruction is 32 bits sent MSB first. SCK is high for exactly `HALF` clocks per bit, and `mosi` never changes while SCK is high or as it rises.
- R4: The first instruction after the wait is the enable word 0xAC530000.
- R5: The byte shifted in on `miso` during the third byte of the enable word is compared with 0x53. The whole 32-bit word is sent whether or not the echo matches.
- R6: On a mismatch `tgt_rst` goes high for exactly `RST_PULSE` clocks and then low. The block then repeats the `PWR_WAIT` hold and sends the enable word again.
- R7: When `MAX_TRIES` enable words in a row get a wrong echo, the block returns to idle with `err` = 1. It sends no page instructions and releases `tgt_rst` high.
- R8: The page is loaded for word indices 0 to 31 in ascending order. Each index sends the low-byte load {0x40, 0x00, 3'b0, index[4:0], word[7:0]} and then the high-byte load {0x48, 0x00, 3'b0, index[4:0], word[15:8]}, with `buf_addr` = index.
- R9: After the last load, the page write {0x4C, 5'b0, page[5:3], page[2:0], 5'b0, 0x00} is sent, using the page number latched at start.
- R10: With `poll_en` = 0 at start, `done` rises exactly `WR_WAIT` clocks after the last SCK fall of the page write.
- R11: With `poll_en` = 1, the status word 0xF0000000 is sent repeatedly after the page write. The bit received last, bit 0 of the fourth byte, means busy when 1. `done` rises after the first word whose last bit is 0.
- R12: `miso` is sampled in the clock in which SCK rises, so a target that changes `miso` on SCK falling edges is read correctly. A correct echo therefore causes no retry.
- R13: A start while `busy` is 1 has no effect, and the page number and mode latched at the first start are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to program a page |
| page | input | 6 | Page number, latched at start |
| poll_en | input | 1 | 1: poll busy status; 0: fixed write wait |
| buf_addr | output | 5 | Word index into the local page buffer |
| buf_word | input | 16 | Buffer word at `buf_addr` |
| sck | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| tgt_rst | output | 1 | Target reset pin level |
| miso | input | 1 | Serial data from target |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Page written; held until next start |
| err | output | 1 | Enable retries exhausted; held until next start |

## Verification
The target model echoes the previous byte on falling SCK edges. The runs cover five cases: a clean echo with a fixed wait, a clean echo with several busy polls, a wrong echo for one or two attempts before success, and wrong echoes up to and beyond the retry limit. Each run separates a different path: no-retry success, the retry loop with its reset pulse, the limit that ends in error, and the two completion modes. The captured instruction stream is compared word for word, which exposes wrong bit order, wrong low/high ordering and wrong address or page fields. A start issued mid-run with a different page shows whether the latched page is kept.

// File: rtl/spprog_host.sv
module spprog_host #(
  parameter int HALF      = 4,
  parameter int PWR_WAIT  = 20000,
  parameter int RST_PULSE = 20,
  parameter int WR_WAIT   = 5000,
  parameter int MAX_TRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  page,
  input  logic        poll_en,
  output logic [4:0]  buf_addr,
  input  logic [15:0] buf_word,
  output logic        sck,
  output logic        mosi,
  output logic        tgt_rst,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic        err
);

  localparam int TW = $clog2(PWR_WAIT + WR_WAIT + RST_PULSE + HALF + 2);
  localparam int RW = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_LOAD, S_SHIFT, S_PULSE, S_WAITWR} st_t;
  typedef enum logic [1:0] {K_EN, K_LD, K_WR, K_POLL} kind_t;

  st_t          st;
  kind_t        kind;
  logic [TW-1:0] tmr;
  logic [4:0]   bitn, idx;
  logic [31:0]  tx, rx, frm;
  logic         hi, pe;
  logic [5:0]   pg;
  logic [RW-1:0] tries;

  assign mosi     = tx[31];
  assign buf_addr = idx;
  assign busy     = (st != S_IDLE);
  assign tgt_rst  = (st == S_IDLE) || (st == S_PULSE);

  wire half_up = (tmr == TW'(HALF - 1));
  wire echo_ok = (rx[15:8] == 8'h53);

  always_comb begin
    case (kind)
      K_EN:    frm = 32'hAC53_0000;
      K_LD:    frm = {hi ? 8'h48 : 8'h40, 8'h00, 3'b000, idx,
                      hi ? buf_word[15:8] : buf_word[7:0]};
      K_WR:    frm = {8'h4C, 5'b0, pg[5:3], pg[2:0], 5'b0, 8'h00};
      default: frm = 32'hF000_0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_EN; tmr <= '0; bitn <= '0; idx <= '0;
      tx <= '0; rx <= '0; hi <= 1'b0; pe <= 1'b0; pg <= '0;
      tries <= '0; sck <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pg <= page; pe <= poll_en; tries <= '0;
          done <= 1'b0; err <= 1'b0; tmr <= '0; st <= S_HOLD;
        end
        S_HOLD: if (tmr == TW'(PWR_WAIT - 1)) begin
          tmr <= '0; kind <= K_EN; st <= S_LOAD;
        end else tmr <= tmr + 1'b1;
        S_LOAD: begin
          tx <= frm; tmr <= '0; bitn <= '0; sck <= 1'b0; st <= S_SHIFT;
        end
        S_SHIFT: if (!half_up) tmr <= tmr + 1'b1;
        else begin
          tmr <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[30:0], miso};
          end else begin
            sck  <= 1'b0;
            tx   <= {tx[30:0], 1'b0};
            bitn <= bitn + 5'd1;
            if (bitn == 5'd31) begin
              case (kind)
                K_EN:
                  if (echo_ok) begin
                    kind <= K_LD; idx <= '0; hi <= 1'b0; st <= S_LOAD;
                  end else if (tries == RW'(MAX_TRIES - 1)) begin
                    err <= 1'b1; st <= S_IDLE;
                  end else begin
                    tries <= tries + 1'b1; st <= S_PULSE;
                  end
                K_LD:
                  if (!hi) begin
                    hi <= 1'b1; st <= S_LOAD;
                  end else if (idx == 5'd31) begin
                    kind <= K_WR; st <= S_LOAD;
                  end else begin
                    idx <= idx + 5'd1; hi <= 1'b0; st <= S_LOAD;
                  end
                K_WR:
                  if (pe) begin
                    kind <= K_POLL; st <= S_LOAD;
                  end else st <= S_WAITWR;
                default:
                  if (rx[0]) st <= S_LOAD;
                  else begin
                    done <= 1'b1; st <= S_IDLE;
                  end
              endcase
            end
          end
        end
        S_PULSE: if (tmr == TW'(RST_PULSE - 1)) begin
          tmr <= '0; st <= S_HOLD;
        end else tmr <= tmr + 1'b1;
        S_WAITWR: if (tmr == TW'(WR_WAIT - 1)) begin
          tmr <= '0; done <= 1'b1; st <= S_IDLE;
        end else tmr <= tmr + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: data is held through the high phase and at the rising edge
  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R2: the clock only toggles while the target is held in reset
  a_r2_sck_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !tgt_rst);

  // R7: error is only reported from idle, never with completion
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done && tgt_rst));

  // R10: completion only ends an active sequence
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R6: a reset pulse never starts with the clock high
  a_r6_pulse_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_rst) && busy) |-> !sck);

  // R13: a start while busy leaves the latched page untouched
  a_r13_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pg));

endmodule

// File: tb/sim_spprog_host.sv
module sim_spprog_host;
  localparam int HALF = 2, PWR_WAIT = 40, RST_PULSE = 6, WR_WAIT = 50, MAX_TRIES = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, poll_en = 1'b0, miso = 1'b0;
  logic [5:0] page_in = '0, cur_pg = '0;
  logic [4:0] buf_addr;
  logic [15:0] buf_word;
  logic sck, mosi, tgt_rst, busy, done, err;

  int checks = 0, failures = 0;
  int cyc = 0, hi_run = 0, pw_last = 0, pulse_cnt = 0, sck_run = 0, sck_hw = 0, last_fall = 0;
  logic prev_rst = 1'b1;

  logic [31:0] frames [0:1023];
  int nfr = 0, en_count = 0, poll_count = 0;
  int en_base = 0, poll_base = 0, bad_n = 0, busy_n = 0;
  logic [31:0] cur = '0;
  logic [4:0] bc = '0;
  logic [7:0] hist = '0, fb = '0;

  always #4 clk = ~clk;

  function automatic logic [15:0] bw(input logic [5:0] p, input logic [4:0] a);
    return {3'b101, a, p, 2'b11};
  endfunction

  assign buf_word = bw(cur_pg, buf_addr);

  spprog_host #(.HALF(HALF), .PWR_WAIT(PWR_WAIT), .RST_PULSE(RST_PULSE),
                .WR_WAIT(WR_WAIT), .MAX_TRIES(MAX_TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page_in), .poll_en(poll_en),
    .buf_addr(buf_addr), .buf_word(buf_word), .sck(sck), .mosi(mosi),
    .tgt_rst(tgt_rst), .miso(miso), .busy(busy), .done(done), .err(err));

  // target model: capture on rising SCK
  always @(posedge sck) begin
    logic [31:0] nx;
    nx = {cur[30:0], mosi};
    cur  <= nx;
    hist <= {hist[6:0], mosi};
    if (bc == 5'd7) fb <= nx[7:0];
    if (bc == 5'd31) begin
      frames[nfr] <= nx;
      nfr <= nfr + 1;
      if (nx[31:24] == 8'hAC) en_count <= en_count + 1;
      if (nx[31:24] == 8'hF0) poll_count <= poll_count + 1;
    end
    bc <= bc + 5'd1;
  end

  // target model: echo previous byte, changed on falling SCK
  always @(negedge sck) begin
    if (bc == 5'd31 && fb == 8'hF0)
      miso <= ((poll_count - poll_base) < busy_n);
    else
      miso <= hist[7] ^ (fb == 8'hAC && (en_count - en_base) < bad_n);
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (tgt_rst && busy) hi_run = hi_run + 1;
    else if (hi_run != 0) begin pw_last = hi_run; hi_run = 0; end
    if (tgt_rst && !prev_rst && busy) pulse_cnt = pulse_cnt + 1;
    prev_rst = tgt_rst;
    if (sck) sck_run = sck_run + 1;
    else if (sck_run != 0) begin sck_hw = sck_run; sck_run = 0; last_fall = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic run_case(input logic [5:0] p, input bit pol, input int bad, input int bsy, input bit poke);
    int base, p0, t0, n, ne, nexp, j, w, bad_at;
    bit ex_err;
    logic [31:0] e;
    tick();
    en_base = en_count; poll_base = poll_count; bad_n = bad; busy_n = bsy;
    cur_pg = p; page_in = p; poll_en = pol; base = nfr; p0 = pulse_cnt;
    start = 1'b1; t0 = cyc;
    tick(); start = 1'b0;
    chk(busy && !tgt_rst && !sck, "R2 reset driven low at start", {busy, tgt_rst, sck}, 3'b100);
    n = 0;
    while (!sck && n < 60000) begin tick(); n++; end
    chk(cyc - t0 >= PWR_WAIT, "R2 hold before first SCK rise", cyc - t0, PWR_WAIT);
    if (poke) begin
      page_in = ~p; poll_en = ~pol; start = 1'b1; tick(); start = 1'b0;
      chk(busy, "R13 start while busy ignored", busy, 1);
    end
    n = 0;
    while (!(done || err) && n < 60000) begin tick(); n++; end
    chk(n < 60000, "R10 watchdog run ended", n, 0);
    ex_err = (bad >= MAX_TRIES);
    ne = ex_err ? MAX_TRIES : bad + 1;
    chk(err == ex_err && done == !ex_err, "R7 outcome", {done, err}, {!ex_err, ex_err});
    chk(pulse_cnt - p0 == ne - 1, "R6 reset pulse count", pulse_cnt - p0, ne - 1);
    if (ne > 1) chk(pw_last == RST_PULSE, "R6 reset pulse width", pw_last, RST_PULSE);
    if (bad == 0) chk(pulse_cnt == p0, "R12 clean echo needs no retry", pulse_cnt - p0, 0);
    chk(sck_hw == HALF, "R3 SCK high width", sck_hw, HALF);
    nexp = ne + (ex_err ? 0 : 65 + (pol ? bsy + 1 : 0));
    chk(nfr - base == nexp, "R5 instruction count", nfr - base, nexp);
    bad_at = -1;
    for (int k = 0; k < ne; k++) if (frames[base + k] != 32'hAC53_0000 && bad_at < 0) bad_at = k;
    chk(bad_at < 0, "R4 enable words", bad_at < 0 ? 0 : frames[base + bad_at], 32'hAC53_0000);
    if (!ex_err) begin
      bad_at = -1;
      for (int k = 0; k < 64; k++) begin
        j = k / 2;
        w = bw(p, 5'(j));
        e = (k % 2 == 0) ? {8'h40, 8'h00, 3'b0, 5'(j), w[7:0]} : {8'h48, 8'h00, 3'b0, 5'(j), w[15:8]};
        if (frames[base + ne + k] != e && bad_at < 0) bad_at = k;
      end
      chk(bad_at < 0, "R8 page load order and content", bad_at, -1);
      e = {8'h4C, 5'b0, p, 5'b0, 8'h00};
      chk(frames[base + ne + 64] == e, "R9 page write word", frames[base + ne + 64], e);
      if (pol) begin
        bad_at = -1;
        for (int k = 0; k <= bsy; k++) if (frames[base + ne + 65 + k] != 32'hF000_0000) bad_at = k;
        chk(bad_at < 0, "R11 status polls", bad_at, -1);
      end else
        chk(cyc - last_fall >= WR_WAIT && cyc - last_fall <= WR_WAIT + 1,
            "R10 fixed write wait", cyc - last_fall, WR_WAIT);
    end
    tick();
    chk(tgt_rst && !busy && !sck, "R1 idle after finish", {tgt_rst, busy, sck}, 3'b100);
  endtask

  // page, poll, bad echoes, busy polls, poke
  localparam logic [13:0] VEC [6] = '{
    {6'd0,  1'b0, 3'd0, 3'd0, 1'b0},
    {6'd63, 1'b1, 3'd0, 3'd3, 1'b0},
    {6'd21, 1'b0, 3'd1, 3'd0, 1'b0},
    {6'd42, 1'b1, 3'd2, 3'd0, 1'b0},
    {6'd7,  1'b0, 3'd3, 3'd0, 1'b0},
    {6'd5,  1'b1, 3'd5, 3'd1, 1'b0}
  };

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(tgt_rst && !sck && !mosi && !busy && !done && !err, "R1 reset state",
        {tgt_rst, sck, mosi, busy, done, err}, 6'b100000);
    for (int i = 0; i < 6; i++)
      run_case(VEC[i][13:8], VEC[i][7], int'(VEC[i][6:4]), int'(VEC[i][3:1]), VEC[i][0]);
    run_case(6'd44, 1'b0, 0, 0, 1'b1);
    run_case(6'd19, 1'b1, 0, 0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 195000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule